// File: doc/BRIEF.md
# PCI Outbound Window Translator

This block sits beside a PCI host bridge and turns CPU-side window accesses into PCI bus addresses. Software programs a small bank of 32-bit control registers: three map registers, three secondary map registers, an identity word and a flags word. Each of the three map registers sets the PCI-side base of one CPU-visible memory window.

A translation request names a window and gives an address relative to that window. The block folds the relative address into the window's size, adds the window base, and returns the 32-bit PCI address one cycle later.

A build-time parameter picks one of two translation flavours. In nibble mode the base is the map value shifted into the top four address bits. In aligned mode the base is the map value with its low bits cleared to the window size. Each flavour has its own set of window sizes.

Translation uses a valid/ready request and response pair. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the response slot is empty or is being drained in the same cycle. A response stays valid and unchanged until it is taken with `rsp_ready`. The register port is a plain strobe interface.

Top module: `win_xlat_top`

## Requirements
- R1: Register words decode as follows. Map windows 0/1/2 are at byte offsets 0x00/0x04/0x08, the identity word is at 0x0C and the flags word at 0x10. Secondary maps 0/1/2 are at 0x14/0x18/0x1C. A read with `reg_rd` returns the stored value on `reg_rdata` in the cycle after the strobe edge. `reg_rdata` is zero in cycles that follow no valid read.
- R2: Reset (`rst_n` low) clears all eight registers to zero and empties the response slot. After reset every window base is zero.
- R3: Only full-word accesses with `reg_be` = 4'hF are valid. A write with any other strobe pattern changes no register and pulses `reg_err`. A read with any other pattern returns zero.
- R4: Undefined offsets are those at or above 0x20, or not word aligned. Reads there return zero. Writes there change nothing and raise `reg_err` for exactly the one cycle after the write edge.
- R5: In nibble mode (`MODE` = XL_SHIFT) a window base equals its map value shifted left by 28, so only map bits 3:0 matter.
- R6: In aligned mode (`MODE` = XL_MASKED) a window base equals its map value ANDed with NOT(window size - 1).
- R7: Window sizes 0/1/2 are 0x0C000000/0x10000000/0x10000000 in nibble mode and 0x01000000/0x04000000/0x08000000 in aligned mode.
- R8: The PCI address is the window base plus (relative address modulo window size), wrapping at 32 bits.
- R9: A map write takes effect for the next request. A request taken on the same edge as the write still uses the old base.
- R10: A request with window index 3 returns PCI address zero.
- R11: `req_ready` equals NOT `rsp_valid` OR `rsp_ready`. A taken request shows on `rsp_valid`/`rsp_addr` one cycle later. While `rsp_valid` is high and `rsp_ready` is low, the response holds stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_be | input | 4 | Byte strobes; only 4'hF is valid |
| reg_addr | input | ADDR_W (8) | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| reg_err | output | 1 | One-cycle pulse after an invalid write |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Translation request can be taken |
| req_win | input | 2 | Window index 0..2 (3 unmapped) |
| req_rel | input | 28 | Window-relative address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_addr | output | 32 | Translated PCI address |

## Verification
Read data, the error pulse and a translation response are each due one clock after the edge that sampled their strobe or handshake. `req_ready` is combinational in the same cycle. A map write shows only in requests taken on later edges. The bench drives inputs just after the falling edge and compares every output against its behavioural model a few nanoseconds later, in the same low phase. Each result is therefore read exactly one registered stage after its cause and before the next rising edge. Directed checks for old-base-versus-new-base, back-pressure hold and reset use the same sampling point against hand-computed constants.

// File: rtl/win_xlat_pkg.sv
package win_xlat_pkg;
  localparam int DATA_W = 32;
  localparam int N_WIN  = 3;
  localparam int WIN_W  = 2;
  localparam int REL_W  = 28;

  typedef enum logic {
    XL_SHIFT  = 1'b0,
    XL_MASKED = 1'b1
  } xl_mode_e;

  // Window size for a given flavour and window number.
  function automatic logic [DATA_W-1:0] win_size(input xl_mode_e mode, input int w);
    if (mode == XL_SHIFT) begin
      return (w == 0) ? 32'h0C00_0000 : 32'h1000_0000;
    end
    case (w)
      0:       return 32'h0100_0000;
      1:       return 32'h0400_0000;
      default: return 32'h0800_0000;
    endcase
  endfunction
endpackage

// File: rtl/win_xlat_regs.sv
module win_xlat_regs
  import win_xlat_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NWIN   = N_WIN
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr,
  input  logic                        rd,
  input  logic [3:0]                  be,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           rdata,
  output logic                        err,
  output logic [NWIN-1:0][DATA_W-1:0] map_o
);
  localparam int WORD_W    = ADDR_W - 2;
  localparam int ID_WORD   = NWIN;
  localparam int FLAG_WORD = NWIN + 1;
  localparam int SMAP_WORD = NWIN + 2;

  logic [NWIN-1:0][DATA_W-1:0] map_q, smap_q;
  logic [DATA_W-1:0]           id_q, flags_q;

  logic [WORD_W-1:0] widx;
  logic              full, aligned, known, acc_ok;
  logic              hit_id, hit_flags;
  logic [NWIN-1:0]   hit_map, hit_smap;
  logic [DATA_W-1:0] rval;

  always_comb begin
    widx      = addr[ADDR_W-1:2];
    full      = (be == 4'hF);
    aligned   = (addr[1:0] == 2'b00);
    hit_id    = aligned && (widx == WORD_W'(ID_WORD));
    hit_flags = aligned && (widx == WORD_W'(FLAG_WORD));
    rval      = '0;
    if (hit_id)    rval = rval | id_q;
    if (hit_flags) rval = rval | flags_q;
    for (int w = 0; w < NWIN; w++) begin
      hit_map[w]  = aligned && (widx == WORD_W'(w));
      hit_smap[w] = aligned && (widx == WORD_W'(SMAP_WORD + w));
      if (hit_map[w])  rval = rval | map_q[w];
      if (hit_smap[w]) rval = rval | smap_q[w];
    end
    known  = (|hit_map) || (|hit_smap) || hit_id || hit_flags;
    acc_ok = full && known;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q   <= '0;
      smap_q  <= '0;
      id_q    <= '0;
      flags_q <= '0;
      rdata   <= '0;
      err     <= 1'b0;
    end else begin
      err   <= wr && !acc_ok;
      rdata <= (rd && acc_ok) ? rval : '0;
      if (wr && acc_ok) begin
        if (hit_id)    id_q    <= wdata;
        if (hit_flags) flags_q <= wdata;
        for (int w = 0; w < NWIN; w++) begin
          if (hit_map[w])  map_q[w]  <= wdata;
          if (hit_smap[w]) smap_q[w] <= wdata;
        end
      end
    end
  end

  assign map_o = map_q;

  // R3 / R4: a rejected write leaves every register untouched
  p_bad_write_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !(full && known)) |=> ($stable(map_q) && $stable(smap_q) &&
                                  $stable(id_q) && $stable(flags_q)));

  // R3: a partial-strobe read yields zero
  p_partial_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (be != 4'hF)) |=> (rdata == '0));
endmodule

// File: rtl/win_xlat_base.sv
module win_xlat_base
  import win_xlat_pkg::*;
#(
  parameter xl_mode_e MODE = XL_SHIFT,
  parameter int       NWIN = N_WIN
) (
  input  logic [NWIN-1:0][DATA_W-1:0] map_i,
  output logic [NWIN-1:0][DATA_W-1:0] base_o
);
  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam logic [DATA_W-1:0] SZ = win_size(MODE, w);
    if (MODE == XL_SHIFT) begin : g_shift
      assign base_o[w] = map_i[w] << 28;
    end else begin : g_mask
      assign base_o[w] = map_i[w] & ~(SZ - 32'd1);
    end
  end
endmodule

// File: rtl/win_xlat_pipe.sv
module win_xlat_pipe
  import win_xlat_pkg::*;
#(
  parameter xl_mode_e MODE = XL_SHIFT,
  parameter int       NWIN = N_WIN
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NWIN-1:0][DATA_W-1:0] base_i,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [WIN_W-1:0]            in_win,
  input  logic [REL_W-1:0]            in_rel,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [DATA_W-1:0]           out_addr
);
  logic [NWIN-1:0][DATA_W-1:0] cand;
  logic [DATA_W-1:0]           addr_nx;
  logic [DATA_W-1:0]           rel32;

  assign rel32 = DATA_W'(in_rel);

  for (genvar w = 0; w < NWIN; w++) begin : g_fold
    localparam logic [DATA_W-1:0] SZ    = win_size(MODE, w);
    localparam int                SZW   = $clog2(SZ);
    localparam logic [DATA_W-1:0] SMASK = (32'd1 << SZW) - 32'd1;
    logic [DATA_W-1:0] trunc, fold;
    always_comb begin
      trunc   = rel32 & SMASK;
      fold    = (trunc >= SZ) ? (trunc - SZ) : trunc;
      cand[w] = base_i[w] + fold;
    end
  end

  always_comb begin
    addr_nx = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (in_win == WIN_W'(w)) addr_nx = cand[w];
    end
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_addr <= addr_nx;
    end
  end

  p_ready_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_win >= WIN_W'(NWIN))) |=> (out_addr == '0));
endmodule

// File: rtl/win_xlat_top.sv
module win_xlat_top
  import win_xlat_pkg::*;
#(
  parameter xl_mode_e MODE   = XL_SHIFT,
  parameter int       ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_be,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_err,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [WIN_W-1:0]  req_win,
  input  logic [REL_W-1:0]  req_rel,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_addr
);
  logic [N_WIN-1:0][DATA_W-1:0] map_w, base_w;

  win_xlat_regs #(.ADDR_W(ADDR_W), .NWIN(N_WIN)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (reg_wr),
    .rd    (reg_rd),
    .be    (reg_be),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .err   (reg_err),
    .map_o (map_w)
  );

  win_xlat_base #(.MODE(MODE), .NWIN(N_WIN)) u_base (
    .map_i  (map_w),
    .base_o (base_w)
  );

  win_xlat_pipe #(.MODE(MODE), .NWIN(N_WIN)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .base_i    (base_w),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_win    (req_win),
    .in_rel    (req_rel),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_addr  (rsp_addr)
  );
endmodule

// File: tb/tb_win_xlat_top.sv
module tb_win_xlat_top;
  import win_xlat_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd, req_valid, rsp_ready;
  logic [3:0]  reg_be;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [1:0]  req_win;
  logic [27:0] req_rel;
  logic [31:0] rdata_a, rdata_b, rsp_a, rsp_b;
  logic        err_a, err_b, rdy_a, rdy_b, vld_a, vld_b;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  win_xlat_top #(.MODE(XL_SHIFT)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_be(reg_be),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_a), .reg_err(err_a),
    .req_valid(req_valid), .req_ready(rdy_a), .req_win(req_win), .req_rel(req_rel),
    .rsp_valid(vld_a), .rsp_ready(rsp_ready), .rsp_addr(rsp_a));

  win_xlat_top #(.MODE(XL_MASKED)) dut_b (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_be(reg_be),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_b), .reg_err(err_b),
    .req_valid(req_valid), .req_ready(rdy_b), .req_win(req_win), .req_rel(req_rel),
    .rsp_valid(vld_b), .rsp_ready(rsp_ready), .rsp_addr(rsp_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_map [3];
  logic [31:0] m_smap[3];
  logic [31:0] m_id, m_flags, m_rd, m_a, m_b;
  logic        m_err, m_ov;

  function automatic int slot(input logic [7:0] a);
    if (a[1:0] != 2'b00 || a >= 8'h20) return -1;
    return int'(a >> 2);
  endfunction

  function automatic logic [31:0] mread(input int s);
    case (s)
      0, 1, 2: return m_map[s];
      3:       return m_id;
      4:       return m_flags;
      default: return m_smap[s-5];
    endcase
  endfunction

  function automatic logic [31:0] exp_addr(input int mode, input int w,
                                           input logic [27:0] rel, input logic [31:0] m);
    logic [31:0] sz, base;
    if (w > 2) return 32'h0;
    if (mode == 0) sz = (w == 0) ? 32'h0C00_0000 : 32'h1000_0000;
    else           sz = (w == 0) ? 32'h0100_0000 : (w == 1) ? 32'h0400_0000 : 32'h0800_0000;
    base = (mode == 0) ? (m << 28) : (m & ~(sz - 32'd1));
    return base + ({4'h0, rel} % sz);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int  s;
    bit  ok;
    int  w;
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin m_map[i] <= '0; m_smap[i] <= '0; end
      m_id <= '0; m_flags <= '0; m_rd <= '0; m_err <= 1'b0;
      m_ov <= 1'b0; m_a <= '0; m_b <= '0;
    end else begin
      s  = slot(reg_addr);
      ok = (reg_be == 4'hF) && (s >= 0);
      m_err <= reg_wr && !ok;
      m_rd  <= (reg_rd && ok) ? mread(s) : 32'h0;
      if (reg_wr && ok) begin
        if (s < 3)       m_map[s]    <= reg_wdata;
        else if (s == 3) m_id        <= reg_wdata;
        else if (s == 4) m_flags     <= reg_wdata;
        else             m_smap[s-5] <= reg_wdata;
      end
      if (!m_ov || rsp_ready) begin
        m_ov <= req_valid;
        if (req_valid) begin
          w = int'(req_win);
          m_a <= exp_addr(0, w, req_rel, m_map[(w > 2) ? 0 : w]);
          m_b <= exp_addr(1, w, req_rel, m_map[(w > 2) ? 0 : w]);
        end
      end
    end
  end

  // Compare every cycle, mid low phase, after inputs settle
  always begin
    @(negedge clk);
    #3;
    if (rst_n) begin
      chk("R1 rdata mode A", rdata_a, m_rd);
      chk("R1 rdata mode B", rdata_b, m_rd);
      chk("R4 err mode A", {31'h0, err_a}, {31'h0, m_err});
      chk("R4 err mode B", {31'h0, err_b}, {31'h0, m_err});
      chk("R11 valid A", {31'h0, vld_a}, {31'h0, m_ov});
      chk("R11 valid B", {31'h0, vld_b}, {31'h0, m_ov});
      chk("R11 ready A", {31'h0, rdy_a}, {31'h0, (!m_ov || rsp_ready)});
      chk("R11 ready B", {31'h0, rdy_b}, {31'h0, (!m_ov || rsp_ready)});
      if (m_ov) begin
        chk("R8 addr mode A", rsp_a, m_a);
        chk("R8 addr mode B", rsp_b, m_b);
      end
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] a, input logic [3:0] be,
                       input logic [31:0] exp, input string req);
    reg_rd = 1'b1; reg_addr = a; reg_be = be;
    step();
    reg_rd = 1'b0;
    chk(req, rdata_a, exp);
    chk(req, rdata_b, exp);
  endtask

  task automatic do_xl(input logic [1:0] w, input logic [27:0] rel,
                       input logic [31:0] ea, input logic [31:0] eb, input string req);
    req_valid = 1'b1; req_win = w; req_rel = rel; rsp_ready = 1'b1;
    step();
    req_valid = 1'b0;
    chk(req, {31'h0, vld_a}, 32'h1);
    chk({req, " mode A"}, rsp_a, ea);
    chk({req, " mode B"}, rsp_b, eb);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL R11 watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_be = 4'hF; reg_addr = '0; reg_wdata = '0;
    req_valid = 0; req_win = '0; req_rel = '0; rsp_ready = 1'b1;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R2: reset state
    chk("R2 rsp_valid after reset", {31'h0, vld_a}, 32'h0);
    chk("R2 err after reset", {31'h0, err_a}, 32'h0);
    do_rd(8'h00, 4'hF, 32'h0, "R2 map0 reset");
    do_rd(8'h1C, 4'hF, 32'h0, "R2 smap2 reset");
    do_xl(2'd1, 28'h0ABCDEF, 32'h00AB_CDEF, 32'h00AB_CDEF, "R2 zero base");

    // R1: program and read back every word
    do_wr(8'h00, 32'h1234_5675, 4'hF);
    do_wr(8'h04, 32'h8ABC_DEF1, 4'hF);
    do_wr(8'h08, 32'hFFFF_FFFF, 4'hF);
    do_wr(8'h0C, 32'h0000_CAFE, 4'hF);
    do_wr(8'h10, 32'h0000_0013, 4'hF);
    do_wr(8'h14, 32'h1111_1111, 4'hF);
    do_wr(8'h18, 32'h2222_2222, 4'hF);
    do_wr(8'h1C, 32'h3333_3333, 4'hF);
    do_rd(8'h04, 4'hF, 32'h8ABC_DEF1, "R1 map1");
    do_rd(8'h0C, 4'hF, 32'h0000_CAFE, "R1 id");
    do_rd(8'h10, 4'hF, 32'h0000_0013, "R1 flags");
    do_rd(8'h18, 4'hF, 32'h2222_2222, "R1 smap1");

    // R5 / R6 / R7 / R8: both flavours
    do_xl(2'd0, 28'hD00_0010, 32'h5100_0010, 32'h1200_0010, "R7 win0 fold");
    do_xl(2'd1, 28'h400_0004, 32'h1400_0004, 32'h8800_0004, "R6 win1 base");
    do_xl(2'd2, 28'hFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 win2 top");
    do_xl(2'd3, 28'h123_4567, 32'h0, 32'h0, "R10 unmapped");

    // R9: request on the same edge as a map write sees the old base
    reg_wr = 1'b1; reg_addr = 8'h00; reg_wdata = 32'h0000_0002; reg_be = 4'hF;
    req_valid = 1'b1; req_win = 2'd0; req_rel = '0;
    step();
    reg_wr = 1'b0; req_valid = 1'b0;
    chk("R9 old base A", rsp_a, 32'h5000_0000);
    chk("R9 old base B", rsp_b, 32'h1200_0000);
    do_xl(2'd0, 28'h0, 32'h2000_0000, 32'h0000_0000, "R9 new base");

    // R3: partial strobes
    do_wr(8'h04, 32'h0, 4'h3);
    chk("R3 partial write err", {31'h0, err_a}, 32'h1);
    do_rd(8'h04, 4'hF, 32'h8ABC_DEF1, "R3 map1 unchanged");
    do_rd(8'h04, 4'h7, 32'h0, "R3 partial read");

    // R4: undefined offsets
    do_wr(8'h20, 32'hDEAD_BEEF, 4'hF);
    chk("R4 undefined write err", {31'h0, err_b}, 32'h1);
    step();
    chk("R4 err one cycle", {31'h0, err_b}, 32'h0);
    do_wr(8'h06, 32'hDEAD_BEEF, 4'hF);
    chk("R4 unaligned write err", {31'h0, err_a}, 32'h1);
    do_rd(8'h24, 4'hF, 32'h0, "R4 undefined read");
    do_rd(8'h08, 4'hF, 32'hFFFF_FFFF, "R4 map2 unchanged");

    // R11: back-pressure
    rsp_ready = 1'b0; req_valid = 1'b1; req_win = 2'd1; req_rel = 28'h5;
    step();
    req_win = 2'd2; req_rel = 28'h0;
    chk("R11 ready low when full", {31'h0, rdy_a}, 32'h0);
    chk("R11 first resp A", rsp_a, 32'h1000_0005);
    step();
    chk("R11 hold A", rsp_a, 32'h1000_0005);
    chk("R11 hold B", rsp_b, 32'h8800_0005);
    rsp_ready = 1'b1;
    step();
    req_valid = 1'b0;
    chk("R11 second resp A", rsp_a, 32'hF000_0000);
    chk("R11 second resp B", rsp_b, 32'hF800_0000);
    step();
    chk("R11 drained", {31'h0, vld_a}, 32'h0);

    // R2: reset after programming clears registers
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    step();
    do_rd(8'h08, 4'hF, 32'h0, "R2 map2 cleared");
    do_rd(8'h14, 4'hF, 32'h0, "R2 smap0 cleared");
    do_xl(2'd2, 28'h10, 32'h0000_0010, 32'h0000_0010, "R2 base cleared");

    repeat (2) step();
    summary();
    $finish;
  end
endmodule